// File: doc/BRIEF.md
# Serial Byte Transmitter with Flow Control

This block turns queued bytes into an asynchronous serial stream. Each character is one low start bit, then 5 to 8 data bits least significant first, then an optional parity bit, then one or two high stop bits. Bytes come in through a write port into an internal queue. That queue holds 64 bytes in normal mode, or a single byte when queueing is switched off. A baud tick input paces every bit. One bit lasts either 16 or 8 ticks.

New characters can be held back in two ways. The first is a clear-to-send input. The second is in-band pause and resume characters taken from the neighbouring receiver. Both act only between characters, so a character that has started is always finished. A break control forces the line low at once and keeps new characters from starting.

Top module: `uart_tx_fc`

## Requirements
- R1: After reset, tx_o is high, busy_o is low and full_o is low.
- R2: The line idles high. A character opens with a low start bit lasting one bit period, sends its data bits least significant first, and closes with high stop bits.
- R3: len_i sets the data bit count: 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Byte bits above that count are not sent.
- R4: When par_en_i is high, one parity bit follows the data. With par_stick_i low, par_odd_i=0 gives even parity (the bit equals the XOR of the sent data bits) and par_odd_i=1 gives odd parity. With par_stick_i high, the bit is the constant value of par_odd_i.
- R5: two_stop_i=0 sends one stop bit and two_stop_i=1 sends two.
- R6: os8_i=0 makes each bit last 16 baud ticks and os8_i=1 makes it last 8. The bit period follows the tick rate.
- R7: With fifo_en_i high, up to 64 bytes are queued and sent in write order. full_o is high while 64 are held, and a write while full is dropped.
- R8: With fifo_en_i low, the queue holds one byte. full_o rises once an unsent byte is held, and a further write is dropped.
- R9: With cts_en_i high and cts_i low, no new character starts. A character already in progress completes.
- R10: With sw_fc_en_i high, a received byte (rx_valid_i) equal to xoff_i pauses transmission at the next character boundary. A received byte equal to xon_i resumes it. Clearing sw_fc_en_i also resumes.
- R11: While brk_i is high, tx_o is low in the same cycle and no new character starts. Queued bytes go out after release.
- R12: Frame settings are captured when a character starts. Changing them mid-character does not alter that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one byte into the queue |
| wr_data_i | input | 8 | Byte to write |
| full_o | output | 1 | Queue cannot accept a byte |
| fifo_en_i | input | 1 | 1: 64-byte queue, 0: single holding byte |
| baud_tick_i | input | 1 | Oversampling tick |
| os8_i | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| len_i | input | 2 | Data bit count code |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | Odd parity select / stick value |
| par_stick_i | input | 1 | Constant parity bit |
| two_stop_i | input | 1 | Two stop bits |
| brk_i | input | 1 | Force line low |
| cts_en_i | input | 1 | Honour cts_i |
| cts_i | input | 1 | Peer ready to receive |
| sw_fc_en_i | input | 1 | Enable pause/resume characters |
| xon_i | input | 8 | Resume character value |
| xoff_i | input | 8 | Pause character value |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| tx_o | output | 1 | Serial output |
| busy_o | output | 1 | A character is in progress |

## Verification
full_o changes on the clock edge that captures a write. A queued byte's start bit begins on the edge after that, when flow control allows. Each later bit lasts exactly one bit period of ticks. The brk_i effect on tx_o is combinational and is checked half a cycle after it is driven.

The scoreboard monitor detects the falling start edge and then samples the line at the middle of every bit, half a period and then whole periods later. Sampling in the middle keeps the comparison immune to the one-cycle start latency. Pauses are checked a full idle window after the current character ends, by requiring busy_o low and the remaining expected bytes still pending.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
    logic       par_stick;
    logic       two_stop;
    logic       os8;
  } frame_cfg_t;

  function automatic logic [7:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  function automatic logic calc_parity(input logic [7:0] d, input frame_cfg_t c);
    logic p;
    p = ^(d & len_mask(c.len));
    return c.par_stick ? c.par_odd : (p ^ c.par_odd);
  endfunction
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             single_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [CW-1:0]    cnt_q;
  logic             wr_ok, rd_ok;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = single_i ? (cnt_q != '0) : (cnt_q == CW'(DEPTH));
  assign wr_ok     = wr_en_i && !full_o;
  assign rd_ok     = rd_en_i && !empty_o;
  assign rd_data_o = mem[rd_ptr];
  assign count_o   = cnt_q;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wr_ptr] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= wr_nxt;
      if (rd_ok) rd_ptr <= rd_nxt;
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sw_en_i,
  input  logic          rx_valid_i,
  input  logic [CW-1:0] rx_data_i,
  input  logic [CW-1:0] xon_i,
  input  logic [CW-1:0] xoff_i,
  input  logic          cts_en_i,
  input  logic          cts_i,
  input  logic          brk_i,
  output logic          allow_o
);
  logic paused_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          paused_q <= 1'b0;
    else if (!sw_en_i)                    paused_q <= 1'b0;
    else if (rx_valid_i) begin
      if (rx_data_i == xoff_i)            paused_q <= 1'b1;  // pause wins on equal codes
      else if (rx_data_i == xon_i)        paused_q <= 1'b0;
    end
  end

  assign allow_o = !paused_q && (!cts_en_i || cts_i) && !brk_i;
endmodule

// File: rtl/uart_tx_serial.sv
module uart_tx_serial
  import uart_tx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int OS_HI = 16,
  parameter int OS_LO = 8,
  localparam int OSW  = $clog2(OS_HI),
  localparam int BW   = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  frame_cfg_t    cfg_i,
  input  logic          go_i,
  input  logic [DW-1:0] data_i,
  output logic          pop_o,
  output logic          busy_o,
  output logic          line_o
);
  tx_state_e       state_q;
  frame_cfg_t      cfg_q;
  logic [OSW-1:0]  tick_cnt;
  logic [BW-1:0]   bit_idx;
  logic [DW-1:0]   sh_q;
  logic            par_q, stop2_q;
  logic [OSW-1:0]  period_m1;
  logic [BW-1:0]   last_idx;
  logic            bit_end;

  assign period_m1 = cfg_q.os8 ? OSW'(OS_LO - 1) : OSW'(OS_HI - 1);
  assign last_idx  = BW'(cfg_q.len) + BW'(DW - 4);
  assign bit_end   = tick_i && (tick_cnt == period_m1);
  assign pop_o     = (state_q == ST_IDLE) && go_i;
  assign busy_o    = (state_q != ST_IDLE);

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = sh_q[0];
      ST_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cfg_q    <= '0;
      tick_cnt <= '0;
      bit_idx  <= '0;
      sh_q     <= '0;
      par_q    <= 1'b0;
      stop2_q  <= 1'b0;
    end else if (pop_o) begin
      state_q  <= ST_START;
      cfg_q    <= cfg_i;
      tick_cnt <= '0;
      sh_q     <= data_i;
      par_q    <= calc_parity(data_i, cfg_i);
    end else if (busy_o && tick_i) begin
      if (!bit_end) begin
        tick_cnt <= tick_cnt + OSW'(1);
      end else begin
        tick_cnt <= '0;
        unique case (state_q)
          ST_START: begin
            state_q <= ST_DATA;
            bit_idx <= '0;
          end
          ST_DATA: begin
            sh_q <= sh_q >> 1;
            if (bit_idx == last_idx) begin
              state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
              stop2_q <= cfg_q.two_stop;
            end else begin
              bit_idx <= bit_idx + BW'(1);
            end
          end
          ST_PAR: begin
            state_q <= ST_STOP;
            stop2_q <= cfg_q.two_stop;
          end
          ST_STOP: begin
            if (stop2_q) stop2_q <= 1'b0;
            else         state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tx_fc.sv
module uart_tx_fc
  import uart_tx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int OS_HI = 16,
  parameter int OS_LO = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          full_o,
  input  logic          fifo_en_i,
  input  logic          baud_tick_i,
  input  logic          os8_i,
  input  logic [1:0]    len_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          par_stick_i,
  input  logic          two_stop_i,
  input  logic          brk_i,
  input  logic          cts_en_i,
  input  logic          cts_i,
  input  logic          sw_fc_en_i,
  input  logic [DW-1:0] xon_i,
  input  logic [DW-1:0] xoff_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          tx_o,
  output logic          busy_o
);
  logic          pop, flow_ok, fifo_empty, ser_line;
  logic [DW-1:0] fifo_data;
  logic [CW-1:0] fifo_count;
  frame_cfg_t    cfg;

  assign cfg = '{len: len_i, par_en: par_en_i, par_odd: par_odd_i,
                 par_stick: par_stick_i, two_stop: two_stop_i, os8: os8_i};

  uart_tx_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .single_i (!fifo_en_i),
    .wr_en_i, .wr_data_i,
    .rd_en_i  (pop),
    .rd_data_o(fifo_data),
    .empty_o  (fifo_empty),
    .full_o,
    .count_o  (fifo_count)
  );

  uart_tx_flow #(.CW(DW)) u_flow (
    .clk_i, .rst_ni,
    .sw_en_i (sw_fc_en_i),
    .rx_valid_i, .rx_data_i, .xon_i, .xoff_i,
    .cts_en_i, .cts_i, .brk_i,
    .allow_o (flow_ok)
  );

  uart_tx_serial #(.DW(DW), .OS_HI(OS_HI), .OS_LO(OS_LO)) u_ser (
    .clk_i, .rst_ni,
    .tick_i (baud_tick_i),
    .cfg_i  (cfg),
    .go_i   (flow_ok && !fifo_empty),
    .data_i (fifo_data),
    .pop_o  (pop),
    .busy_o,
    .line_o (ser_line)
  );

  assign tx_o = ser_line && !brk_i;
endmodule

// File: rtl/uart_tx_fc_chk.sv
module uart_tx_fc_chk #(
  parameter int CW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_o,
  input logic          busy_o,
  input logic          brk_i,
  input logic          full_o,
  input logic          wr_en_i,
  input logic          pop,
  input logic          flow_ok,
  input logic          fifo_empty,
  input logic [CW-1:0] fifo_count
);
  p_break_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> !tx_o);

  p_idle_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !brk_i) |-> tx_o);

  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && !brk_i) |-> !tx_o);

  p_start_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |-> (flow_ok && !fifo_empty));

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_en_i && !pop) |=> (fifo_count == $past(fifo_count)));
endmodule

bind uart_tx_fc uart_tx_fc_chk #(.CW(CW)) u_chk (
  .clk_i, .rst_ni, .tx_o, .busy_o, .brk_i, .full_o, .wr_en_i,
  .pop, .flow_ok, .fifo_empty, .fifo_count
);

// File: tb/uart_tx_fc_tb.sv
module uart_tx_fc_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 0, fifo_en = 1, tick = 0, os8 = 0;
  logic [7:0] wr_data = 0, xon = 8'h11, xoff = 8'h13, rx_data = 0;
  logic [1:0] len = 2'b11;
  logic       par_en = 0, par_odd = 0, par_stick = 0, two_stop = 0;
  logic       brk = 0, cts_en = 0, cts = 1, sw_en = 0, rx_valid = 0;
  logic       full, tx, busy;

  int checks = 0, errors = 0, tick_div = 1, tcnt = 0;
  bit mon_en = 1, done = 0;

  typedef struct { logic [11:0] bits; int n; int per; string tag; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  uart_tx_fc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .full_o(full), .fifo_en_i(fifo_en), .baud_tick_i(tick), .os8_i(os8),
    .len_i(len), .par_en_i(par_en), .par_odd_i(par_odd),
    .par_stick_i(par_stick), .two_stop_i(two_stop), .brk_i(brk),
    .cts_en_i(cts_en), .cts_i(cts), .sw_fc_en_i(sw_en), .xon_i(xon),
    .xoff_i(xoff), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .tx_o(tx), .busy_o(busy)
  );

  initial forever begin
    @(posedge clk); #1;
    tcnt++;
    tick = ((tcnt % tick_div) == 0);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_raw(input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  // expectation from current settings, then write
  task automatic send(input logic [7:0] d, input string tag);
    exp_t e;
    int nb, k;
    nb = int'(len) + 5;
    e.bits = '0;
    for (int i = 0; i < nb; i++) e.bits[i] = d[i];
    k = nb;
    if (par_en) begin
      logic p;
      p = 1'b0;
      for (int i = 0; i < nb; i++) p ^= d[i];
      e.bits[k] = par_stick ? par_odd : (p ^ par_odd);
      k++;
    end
    e.bits[k] = 1'b1; k++;
    if (two_stop) begin e.bits[k] = 1'b1; k++; end
    e.n = k;
    e.per = (os8 ? 8 : 16) * tick_div;
    e.tag = tag;
    sb.push_back(e);
    wr_raw(d);
  endtask

  task automatic drain();
    int w = 0;
    while ((sb.size() != 0 || busy) && w < 60000) begin
      @(negedge clk); w++;
    end
    chk("drain", sb.size(), 0);
  endtask

  task automatic rx_byte(input logic [7:0] d);
    @(posedge clk); #1;
    rx_valid = 1; rx_data = d;
    @(posedge clk); #1;
    rx_valid = 0;
  endtask

  // scoreboard monitor: mid-bit sampling
  initial begin
    logic prev = 1'b1, cur;
    exp_t e;
    logic [11:0] got;
    forever begin
      @(negedge clk);
      cur = tx;
      if (mon_en && prev && !cur) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2: actual unexpected frame expected none");
        end else begin
          e = sb.pop_front();
          got = '0;
          repeat (e.per / 2) @(negedge clk);
          chk({e.tag, " start"}, {31'd0, tx}, 0);
          for (int i = 0; i < e.n; i++) begin
            repeat (e.per) @(negedge clk);
            got[i] = tx;
          end
          chk(e.tag, {20'd0, got}, {20'd0, e.bits});
        end
        cur = 1'b1;
      end
      prev = cur;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tx", {31'd0, tx}, 1);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 full", {31'd0, full}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3: every length
    for (int l = 0; l < 4; l++) begin
      len = l[1:0];
      send(8'hB6, "R3 len");
      send(8'h4D, "R2 frame");
      drain();
    end

    // R4 parity modes
    len = 2'b11; par_en = 1;
    par_odd = 0; send(8'h07, "R4 even"); send(8'h03, "R4 even"); drain();
    par_odd = 1; send(8'h07, "R4 odd");  send(8'h03, "R4 odd");  drain();
    par_stick = 1; par_odd = 1; send(8'h00, "R4 stick1"); drain();
    par_odd = 0; send(8'hFF, "R4 stick0"); drain();
    len = 2'b01; par_stick = 0; send(8'hC1, "R4 masked"); drain();
    par_en = 0; len = 2'b11;

    // R5 two stops
    two_stop = 1; send(8'h5A, "R5 two"); send(8'hA5, "R5 two"); drain();
    two_stop = 0;

    // R6 oversampling and tick rate
    os8 = 1; send(8'h39, "R6 os8"); drain();
    tick_div = 2; os8 = 0; send(8'h93, "R6 div2"); drain();
    tick_div = 1;

    // R7 deep queue, overflow dropped
    cts_en = 1; cts = 0;
    for (int i = 0; i < 64; i++) send(8'(i * 3 + 1), "R7 order");
    @(negedge clk);
    chk("R7 full", {31'd0, full}, 1);
    wr_raw(8'hEE);
    chk("R7 idle while blocked", {31'd0, busy}, 0);
    cts = 1;
    drain();
    chk("R7 full clear", {31'd0, full}, 0);

    // R8 single holding byte
    fifo_en = 0; cts = 0;
    send(8'h66, "R8 hold");
    @(negedge clk);
    chk("R8 full", {31'd0, full}, 1);
    wr_raw(8'h99);
    cts = 1;
    drain();
    fifo_en = 1;

    // R9 CTS: current char completes, next held
    send(8'h12, "R9 cur"); send(8'h34, "R9 next");
    wait (busy); #1;
    cts = 0;
    wait (sb.size() == 1 && !busy);
    repeat (300) @(negedge clk);
    chk("R9 paused", {31'd0, busy}, 0);
    chk("R9 pending", sb.size(), 1);
    cts = 1;
    drain();
    cts_en = 0;

    // R10 XOFF/XON
    sw_en = 1;
    send(8'h21, "R10 cur"); send(8'h43, "R10 a"); send(8'h65, "R10 b");
    wait (busy);
    rx_byte(8'h13);
    wait (sb.size() == 2 && !busy);
    repeat (300) @(negedge clk);
    chk("R10 paused", {31'd0, busy}, 0);
    chk("R10 pending", sb.size(), 2);
    rx_byte(8'h55);
    repeat (50) @(negedge clk);
    chk("R10 other char", sb.size(), 2);
    rx_byte(8'h11);
    drain();
    sw_en = 0;

    // R11 break
    mon_en = 0;
    @(posedge clk); #1; brk = 1;
    @(negedge clk);
    chk("R11 low", {31'd0, tx}, 0);
    send(8'h7E, "R11 after");
    repeat (100) @(negedge clk);
    chk("R11 no start", {31'd0, busy}, 0);
    chk("R11 line", {31'd0, tx}, 0);
    @(posedge clk); #1; brk = 0; mon_en = 1;
    drain();

    // R12 settings captured at start
    len = 2'b11;
    send(8'hA5, "R12 latched");
    wait (busy); #1;
    len = 2'b00; par_en = 1;
    drain();
    len = 2'b11; par_en = 0;
    chk("R12 idle", {31'd0, tx}, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule